// File: doc/BRIEF.md
# Programmable field flag toggle generator

This block produces the interlaced field flag for a video timing path with a fixed number of lines per frame (625 by default). A line counter outside the block supplies a one-cycle pulse at the start of every line together with the index of that line. A raw field indication, taken from sync separation, is sampled at each line start. The block records the line on which the raw field changes parity. It then moves the flag's transition away from that nominal boundary by a programmable number of lines. The move can be earlier or later, and either field parity can push its own transition one extra line later.

The computed flag leaves the block on two outputs: the F bit placed in the embedded timing reference code, and a discrete field pin. Both come from one register, so they never disagree. The configuration inputs are static register values. They are sampled only when a frame starts, so every frame runs under a single consistent setting. The boundaries used in a frame are the ones recorded during earlier lines, which lets an advanced transition fall before the boundary it is derived from.

The control has two states. ACQUIRE is entered at reset. In ACQUIRE the flag copies the raw field at each line start, and the two boundaries are learned. The transition "lock" moves to TRACK at the first frame start at which both boundaries have been captured. In TRACK the flag changes only on the computed toggle lines. The transition "hold" keeps TRACK in TRACK from then on.

Top module: `fld_toggle_gen`

## Requirements
- R1: While reset is asserted and after its release, both field_pin and fbit_code are 0 until the first line start.
- R2: In ACQUIRE, at every edge where line_start is 1, the flag takes the value of raw_fld (1 = odd field, 0 = even field).
- R3: A boundary is the line_idx of a line start whose raw_fld differs from the value at the previous line start. It is stored for the parity being entered. A frame uses the boundaries captured before that frame's start line.
- R4: With cfg_adv = 0, the flag becomes parity p on the line (boundary_p + cfg_ofs + d_p) mod LINES. Here d_p is the delay enable for parity p.
- R5: With cfg_adv = 1, the flag becomes parity p on the line (boundary_p - cfg_ofs + d_p) mod LINES, wrapping below line 0 to the end of the frame.
- R6: cfg_dly_odd adds one line only to the transition into the odd field (flag = 1). cfg_dly_even adds one line only to the transition into the even field (flag = 0).
- R7: The flag changes only on a clock edge where line_start is 1, never in the middle of a line.
- R8: All four configuration inputs are sampled on the frame start (line_start with line_idx = 0) and held for the whole frame. A change inside a frame has no effect until the next frame start.
- R9: fbit_code and field_pin carry the same value in every cycle.
- R10: TRACK begins at the first frame start at which boundaries for both parities have been captured. From that frame on, the flag follows only the computed toggle lines.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| line_start | input | 1 | One-cycle pulse at the start of each line |
| line_idx | input | $clog2(LINES) | Index of the line that starts, valid with line_start; 0 marks frame start |
| raw_fld | input | 1 | Raw field parity from sync separation, 1 = odd |
| cfg_ofs | input | 5 | Toggle offset in lines |
| cfg_adv | input | 1 | 1 = move transition earlier, 0 = move it later |
| cfg_dly_odd | input | 1 | Add one line to the transition into the odd field |
| cfg_dly_even | input | 1 | Add one line to the transition into the even field |
| fbit_code | output | 1 | F bit for the embedded timing reference code |
| field_pin | output | 1 | Discrete field output |

## Verification
The hardest situations to reach from the ports are a target line that wraps across the frame edge, and a transition that coincides with the frame start itself. Examples are an advance that places the even-field transition near the end of the previous frame, or a delay setting that lands on line 0. Both can only be seen after the block has locked.

The bench first drives two acquisition frames so that both boundaries are learned. It then sweeps every offset in both directions with all four delay-enable combinations. Each setting gets one warm-up frame followed by a frame whose toggle lines are compared exactly.

Separate scenarios change the configuration in the middle of a frame, and shift the raw odd boundary. These show that both kinds of change take effect only one frame later.

// File: rtl/fld_pkg.sv
package fld_pkg;

    localparam int FLD_OFS_W = 5;

    typedef enum logic {
        ST_ACQUIRE = 1'b0,
        ST_TRACK   = 1'b1
    } fld_state_e;

    typedef struct packed {
        logic [FLD_OFS_W-1:0] ofs;
        logic                 adv;
        logic                 dly_odd;
        logic                 dly_even;
    } fld_cfg_t;

    localparam fld_cfg_t FLD_CFG_RST = '{ofs: FLD_OFS_W'(3), adv: 1'b1, dly_odd: 1'b0, dly_even: 1'b1};

endpackage

// File: rtl/fld_cfg_stage.sv
module fld_cfg_stage
    import fld_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     frame_start,
    input  fld_cfg_t cfg_in,
    output fld_cfg_t cfg_eff,
    output fld_cfg_t cfg_act
);
    fld_cfg_t act_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act_q <= FLD_CFG_RST;
        end else if (frame_start) begin
            act_q <= cfg_in;
        end
    end

    // the frame start line already runs under the newly sampled setting
    assign cfg_eff = frame_start ? cfg_in : act_q;
    assign cfg_act = act_q;
endmodule

// File: rtl/fld_bnd_learn.sv
module fld_bnd_learn #(
    parameter  int LINES = 625,
    localparam int LW    = $clog2(LINES)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                line_start,
    input  logic                frame_start,
    input  logic [LW-1:0]       line_idx,
    input  logic                raw_fld,
    output logic [1:0][LW-1:0]  bnd_eff,
    output logic [1:0][LW-1:0]  bnd_use,
    output logic                seen_both
);
    logic                prev_raw_q;
    logic                prev_ok_q;
    logic [1:0]          seen_q;
    logic [1:0][LW-1:0]  cur_q;
    logic [1:0][LW-1:0]  use_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_raw_q <= 1'b0;
            prev_ok_q  <= 1'b0;
            seen_q     <= '0;
            cur_q      <= '0;
        end else if (line_start) begin
            prev_raw_q <= raw_fld;
            prev_ok_q  <= 1'b1;
            if (prev_ok_q && (raw_fld != prev_raw_q)) begin
                cur_q[raw_fld]  <= line_idx;
                seen_q[raw_fld] <= 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            use_q <= '0;
        end else if (frame_start) begin
            use_q <= cur_q;
        end
    end

    assign bnd_eff   = frame_start ? cur_q : use_q;
    assign bnd_use   = use_q;
    assign seen_both = &seen_q;
endmodule

// File: rtl/fld_tgt_calc.sv
module fld_tgt_calc
    import fld_pkg::*;
#(
    parameter  int LINES = 625,
    localparam int LW    = $clog2(LINES),
    localparam int SW    = LW + 2
) (
    input  logic [LW-1:0]        bnd,
    input  logic [FLD_OFS_W-1:0] ofs,
    input  logic                 adv,
    input  logic                 extra,
    output logic [LW-1:0]        tgt
);
    logic [SW-1:0] b_w, o_w, e_w, l_w, sum_w, red1_w, red2_w;

    always_comb begin
        b_w    = SW'(bnd);
        o_w    = SW'(ofs);
        e_w    = SW'(extra);
        l_w    = SW'(LINES);
        sum_w  = adv ? (b_w + l_w - o_w + e_w) : (b_w + o_w + e_w);
        red1_w = (sum_w >= l_w) ? (sum_w - l_w) : sum_w;
        red2_w = (red1_w >= l_w) ? (red1_w - l_w) : red1_w;
        tgt    = red2_w[LW-1:0];
    end
endmodule

// File: rtl/fld_toggle_gen.sv
module fld_toggle_gen
    import fld_pkg::*;
#(
    parameter  int LINES = 625,
    localparam int LW    = $clog2(LINES)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 line_start,
    input  logic [LW-1:0]        line_idx,
    input  logic                 raw_fld,
    input  logic [FLD_OFS_W-1:0] cfg_ofs,
    input  logic                 cfg_adv,
    input  logic                 cfg_dly_odd,
    input  logic                 cfg_dly_even,
    output logic                 fbit_code,
    output logic                 field_pin
);
    fld_state_e          state_q, state_d;
    fld_cfg_t            cfg_in, cfg_eff, cfg_act;
    logic [1:0][LW-1:0]  bnd_eff, bnd_use;
    logic [1:0][LW-1:0]  tgt;
    logic [1:0]          dly_vec;
    logic                seen_both;
    logic                frame_start;
    logic                flag_q;

    assign frame_start = line_start && (line_idx == '0);
    assign cfg_in      = '{ofs: cfg_ofs, adv: cfg_adv, dly_odd: cfg_dly_odd, dly_even: cfg_dly_even};
    assign dly_vec     = {cfg_eff.dly_odd, cfg_eff.dly_even};

    fld_cfg_stage u_cfg (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_start (frame_start),
        .cfg_in      (cfg_in),
        .cfg_eff     (cfg_eff),
        .cfg_act     (cfg_act)
    );

    fld_bnd_learn #(.LINES(LINES)) u_bnd (
        .clk         (clk),
        .rst_n       (rst_n),
        .line_start  (line_start),
        .frame_start (frame_start),
        .line_idx    (line_idx),
        .raw_fld     (raw_fld),
        .bnd_eff     (bnd_eff),
        .bnd_use     (bnd_use),
        .seen_both   (seen_both)
    );

    // index 0: transition into even, index 1: transition into odd
    for (genvar p = 0; p < 2; p++) begin : g_tgt
        fld_tgt_calc #(.LINES(LINES)) u_tgt (
            .bnd   (bnd_eff[p]),
            .ofs   (cfg_eff.ofs),
            .adv   (cfg_eff.adv),
            .extra (dly_vec[p]),
            .tgt   (tgt[p])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_ACQUIRE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_ACQUIRE: if (frame_start && seen_both) state_d = ST_TRACK;
            ST_TRACK:   state_d = ST_TRACK;
            default:    state_d = ST_ACQUIRE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else if (line_start) begin
            unique case (state_d)
                ST_ACQUIRE: flag_q <= raw_fld;
                ST_TRACK: begin
                    if (line_idx == tgt[1]) begin
                        flag_q <= 1'b1;
                    end else if (line_idx == tgt[0]) begin
                        flag_q <= 1'b0;
                    end
                end
                default: flag_q <= flag_q;
            endcase
        end
    end

    assign fbit_code = flag_q;
    assign field_pin = flag_q;
endmodule

// File: rtl/fld_toggle_chk.sv
module fld_toggle_chk
    import fld_pkg::*;
#(
    parameter  int LINES = 625,
    localparam int LW    = $clog2(LINES)
) (
    input logic                clk,
    input logic                rst_n,
    input logic                line_start,
    input logic [LW-1:0]       line_idx,
    input logic                raw_fld,
    input logic                field_pin,
    input fld_cfg_t            cfg_act,
    input logic [1:0][LW-1:0]  bnd_use,
    input fld_state_e          state_d
);
    // R7
    midline_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !line_start |=> $stable(field_pin));

    // R8
    cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(line_start && line_idx == '0) |=> $stable(cfg_act));

    // R3
    bnd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(line_start && line_idx == '0) |=> $stable(bnd_use));

    // R2
    acquire_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (line_start && state_d == ST_ACQUIRE) |=> (field_pin == $past(raw_fld)));
endmodule

bind fld_toggle_gen fld_toggle_chk #(.LINES(LINES)) u_fld_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .line_start (line_start),
    .line_idx   (line_idx),
    .raw_fld    (raw_fld),
    .field_pin  (field_pin),
    .cfg_act    (cfg_act),
    .bnd_use    (bnd_use),
    .state_d    (state_d)
);

// File: tb/test_fld_toggle_gen.sv
module test_fld_toggle_gen;
    localparam int L    = 125;
    localparam int LW   = $clog2(L);
    localparam int ODD0 = 63;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       line_start = 1'b0;
    logic [LW-1:0] line_idx = '0;
    logic       raw_fld = 1'b0;
    logic [4:0] cfg_ofs = 5'd0;
    logic       cfg_adv = 1'b0;
    logic       cfg_dly_odd = 1'b0;
    logic       cfg_dly_even = 1'b0;
    logic       fbit_code, field_pin;

    always #10 clk = ~clk;

    fld_toggle_gen #(.LINES(L)) i_fld_toggle_gen (
        .clk(clk), .rst_n(rst_n), .line_start(line_start), .line_idx(line_idx),
        .raw_fld(raw_fld), .cfg_ofs(cfg_ofs), .cfg_adv(cfg_adv),
        .cfg_dly_odd(cfg_dly_odd), .cfg_dly_even(cfg_dly_even),
        .fbit_code(fbit_code), .field_pin(field_pin)
    );

    int errors = 0;
    int checks = 0;
    int n_chg;
    int chg_at[4];
    int midline_bad = 0;
    int agree_bad = 0;
    logic prev_pin;
    logic [4:0] pend_ofs;
    logic pend_adv, pend_odd, pend_even;

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic set_cfg(input int o, input int a, input int dodd, input int deven);
        cfg_ofs = 5'(o); cfg_adv = 1'(a); cfg_dly_odd = 1'(dodd); cfg_dly_even = 1'(deven);
    endtask

    function automatic int exp_tgt(input int b, input int o, input int a, input int d);
        int t;
        t = (a != 0) ? (b - o + d) : (b + o + d);
        return ((t % L) + L) % L;
    endfunction

    // drives one frame; changes cfg to the pending values at line cfg_line
    task automatic run_frame(input int odd_start, input int cfg_line);
        n_chg = 0;
        for (int k = 0; k < 4; k++) chg_at[k] = -1;
        for (int l = 0; l < L; l++) begin
            @(negedge clk);
            if (field_pin !== prev_pin) midline_bad++;
            if (l == cfg_line) begin
                cfg_ofs = pend_ofs; cfg_adv = pend_adv;
                cfg_dly_odd = pend_odd; cfg_dly_even = pend_even;
            end
            line_start = 1'b1;
            line_idx   = LW'(l);
            raw_fld    = (l >= odd_start);
            @(negedge clk);
            line_start = 1'b0;
            if (fbit_code !== field_pin) agree_bad++;
            if (field_pin !== prev_pin) begin
                if (n_chg < 4) chg_at[n_chg] = l;
                n_chg++;
            end
            prev_pin = field_pin;
        end
    endtask

    task automatic check_pair(input int e0, input int e1, input string req);
        int lo, hi;
        lo = (e0 < e1) ? e0 : e1;
        hi = (e0 < e1) ? e1 : e0;
        check(n_chg == 2 && chg_at[0] == lo && chg_at[1] == hi, req,
              chg_at[0] * 1000 + chg_at[1], lo * 1000 + hi);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check(field_pin == 1'b0, "R1 field_pin in reset", int'(field_pin), 0);
        check(fbit_code == 1'b0, "R1 fbit_code in reset", int'(fbit_code), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(field_pin == 1'b0 && fbit_code == 1'b0, "R1 after release", int'(field_pin), 0);
        prev_pin = field_pin;
    endtask

    task automatic t_acquire();
        set_cfg(5, 0, 0, 0);
        run_frame(ODD0, -1);
        check(n_chg == 1 && chg_at[0] == ODD0, "R2 first frame follows raw", chg_at[0], ODD0);
        run_frame(ODD0, -1);
        check_pair(0, ODD0, "R2 second frame follows raw");
        run_frame(ODD0, -1);
        check_pair(5, ODD0 + 5, "R10 tracking from third frame");
    endtask

    task automatic t_sweep();
        for (int a = 0; a < 2; a++) begin
            for (int dm = 0; dm < 4; dm++) begin
                for (int o = 0; o < 32; o++) begin
                    int e0, e1;
                    set_cfg(o, a, dm / 2, dm % 2);
                    e0 = exp_tgt(0, o, a, dm % 2);
                    e1 = exp_tgt(ODD0, o, a, dm / 2);
                    run_frame(ODD0, -1);
                    run_frame(ODD0, -1);
                    if (a == 0) check_pair(e0, e1, $sformatf("R4/R6 delay ofs=%0d dly=%0d", o, dm));
                    else        check_pair(e0, e1, $sformatf("R5/R6 advance ofs=%0d dly=%0d", o, dm));
                end
            end
        end
    endtask

    task automatic t_cfg_midframe();
        set_cfg(4, 0, 0, 0);
        run_frame(ODD0, -1);
        pend_ofs = 5'd20; pend_adv = 1'b0; pend_odd = 1'b0; pend_even = 1'b0;
        run_frame(ODD0, 10);
        check_pair(4, ODD0 + 4, "R8 mid-frame change ignored");
        run_frame(ODD0, -1);
        check_pair(20, ODD0 + 20, "R8 change applied next frame");
    endtask

    task automatic t_bnd_shift();
        set_cfg(4, 0, 0, 0);
        run_frame(ODD0, -1);
        run_frame(70, -1);
        check_pair(4, ODD0 + 4, "R3 old boundary in capture frame");
        run_frame(70, -1);
        check_pair(4, 74, "R3 new boundary next frame");
    endtask

    initial begin
        t_reset();
        t_acquire();
        t_sweep();
        t_cfg_midframe();
        t_bnd_shift();
        check(midline_bad == 0, "R7 changes outside line start", midline_bad, 0);
        check(agree_bad == 0, "R9 fbit_code vs field_pin", agree_bad, 0);
        summary();
        $finish;
    end

    initial begin
        repeat (180000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        summary();
        $finish;
    end
endmodule